// File: doc/BRIEF.md
# Masked Calendar Alarm Matcher

This block watches a running time-of-day and calendar value and raises an interrupt when it reaches a programmed instant. It holds two alarms that work independently. Each alarm keeps six bytes, one each for seconds, minutes, hours, date, month and day of week. Each byte has the same value layout as the live clock field it is compared against. The most significant bit of each byte chooses whether that field takes part in the comparison. This lets software build alarms such as "every hour at minute 30", "every Monday" or a single exact instant.

The comparison runs only on a one-cycle second tick. When an alarm matches, its status flag is set. In single-event mode the flag drives the interrupt until software clears it. In repeat mode each match produces a low pulse of fixed length on the interrupt output. The interrupt output is active low and combines both alarms. Software writes the alarm bytes and a per-alarm control byte through a simple write port, and clears flags with a write-one-to-clear mask.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, both alarm flags read 0 and `irqN` is 1. All alarm bytes and control bytes reset to 0, so every field is disabled, the interrupt is masked and single-event mode is selected.
- R2: An alarm matches only when every field whose enable bit (bit 7) is 1 has bits 6:0 equal to the live field. Fields whose enable bit is 0 are ignored. `liveTime` holds field f in bits [7f+6:7f], with f = 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week.
- R3: An alarm with no enabled field never matches, whatever the live value.
- R4: Matching is evaluated only in a cycle where `secTick` is 1. A flag never rises in a cycle without a tick.
- R5: A match sets that alarm's flag at the next clock edge. The flag then stays set until a cycle with `clrEn` = 1 and the alarm's bit set in `clrMask`. In single-event mode, a set flag with the interrupt enabled drives `irqN` low.
- R6: In repeat mode, a match sets the flag and drives `irqN` low for exactly PULSE_CYCLES cycles, starting right after the matching edge. A new match during a pulse restarts the count. In this mode the flag alone does not hold `irqN` low.
- R7: `irqN` is 0 exactly when at least one alarm has its interrupt enabled and is pending: its flag is set in single-event mode, or its pulse is running in repeat mode. With the interrupt disabled, a match still sets the flag.
- R8: When a match and a clear of the same alarm fall in the same cycle, the flag ends up set.
- R9: Write address bit 3 selects the alarm and bits 2:0 select the byte. Slots 0 to 5 are the fields in the order of R2. Slot 6 is control: bit 0 selects repeat mode, bit 7 enables the interrupt. Writes to slot 7 have no effect.
- R10: The two alarms are independent. A write, match or clear of one never changes the other's flag or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| liveTime | input | 42 | Live time and calendar, six 7-bit fields |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address: alarm select and byte slot |
| wrData | input | 8 | Write data |
| clrEn | input | 1 | Flag clear strobe |
| clrMask | input | 2 | Flags to clear, one bit per alarm |
| alarmFlag | output | 2 | Alarm status flags |
| irqN | output | 1 | Active-low combined interrupt |

## Verification
A second tick that matches an alarm can land in the same cycle as a software clear of that alarm's flag. A flag that lost this race would drop an alarm without any trace. The bench provokes the collision directly, by driving a matching tick together with `clrEn` for the same alarm. The random phase also issues ticks and clears in the same cycle on their own. The outcome is judged from the flag and `irqN` after the edge, which must show the alarm as set and pending.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_ALARMS  = 2;
  localparam int NUM_FIELDS  = 6;
  localparam int VAL_W       = 7;
  localparam int BYTE_W      = VAL_W + 1;
  localparam int SLOT_W      = 3;
  localparam int ALARM_SEL_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;
  localparam int ADDR_W      = ALARM_SEL_W + SLOT_W;
  localparam int LIVE_W      = NUM_FIELDS * VAL_W;
  localparam int CTRL_SLOT   = NUM_FIELDS;
  localparam int REPEAT_BIT  = 0;
  localparam int IRQEN_BIT   = BYTE_W - 1;

  typedef enum logic [1:0] {
    SLOT_FIELD,
    SLOT_CTRL,
    SLOT_NONE
  } slot_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_ALARMS-1:0] fieldWr;
    logic [NUM_ALARMS-1:0] ctrlWr;
    logic [SLOT_W-1:0]     fieldSel;
    logic [BYTE_W-1:0]     data;
    logic [NUM_ALARMS-1:0] pulseLoad;
  } strobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  secTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  input  logic [NUM_ALARMS-1:0] matchHit,
  input  logic [NUM_ALARMS-1:0] repeatMode,
  input  logic [NUM_ALARMS-1:0] irqEnable,
  input  logic [NUM_ALARMS-1:0] pulseBusy,
  output strobe_t               strobes,
  output logic [NUM_ALARMS-1:0] alarmFlag,
  output logic                  irqN
);
  logic [SLOT_W-1:0]      slot;
  logic [ALARM_SEL_W-1:0] alarmSel;
  slot_kind_e             slotKind;
  logic [NUM_ALARMS-1:0]  hitVec;
  logic [NUM_ALARMS-1:0]  clrVec;
  logic [NUM_ALARMS-1:0]  pendVec;

  assign slot     = wrAddr[SLOT_W-1:0];
  assign alarmSel = wrAddr[ADDR_W-1:SLOT_W];

  always_comb begin
    if (slot < SLOT_W'(NUM_FIELDS))       slotKind = SLOT_FIELD;
    else if (slot == SLOT_W'(CTRL_SLOT))  slotKind = SLOT_CTRL;
    else                                  slotKind = SLOT_NONE;
  end

  // Tick-qualified hits and the clear vector
  assign hitVec = {NUM_ALARMS{secTick}} & matchHit;
  assign clrVec = clrEn ? clrMask : '0;

  always_comb begin
    strobes.fieldSel  = slot;
    strobes.data      = wrData;
    strobes.pulseLoad = hitVec & repeatMode;
    for (int a = 0; a < NUM_ALARMS; a++) begin
      strobes.fieldWr[a] = wrEn && (slotKind == SLOT_FIELD) && (alarmSel == ALARM_SEL_W'(a));
      strobes.ctrlWr[a]  = wrEn && (slotKind == SLOT_CTRL)  && (alarmSel == ALARM_SEL_W'(a));
    end
  end

  // Set dominates clear
  always_ff @(posedge clk) begin
    if (!rst_n) alarmFlag <= '0;
    else        alarmFlag <= (alarmFlag & ~clrVec) | hitVec;
  end

  // Pending per alarm: latched flag in single mode, running pulse in repeat mode
  assign pendVec = irqEnable & ((repeatMode & pulseBusy) | (~repeatMode & alarmFlag));
  assign irqN    = ~(|pendVec);
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strobes,
  input  logic [LIVE_W-1:0]     liveTime,
  output logic [NUM_ALARMS-1:0] matchHit,
  output logic [NUM_ALARMS-1:0] repeatMode,
  output logic [NUM_ALARMS-1:0] irqEnable,
  output logic [NUM_ALARMS-1:0] pulseBusy
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    logic [NUM_FIELDS-1:0] fieldOn;
    logic [NUM_FIELDS-1:0] fieldOk;
    logic                  repeatReg;
    logic                  irqEnReg;
    logic [CNT_W-1:0]      pulseCnt;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic [BYTE_W-1:0] byteReg;
      always_ff @(posedge clk) begin
        if (!rst_n) byteReg <= '0;
        else if (strobes.fieldWr[a] && strobes.fieldSel == SLOT_W'(f)) byteReg <= strobes.data;
      end
      assign fieldOn[f] = byteReg[BYTE_W-1];
      assign fieldOk[f] = !byteReg[BYTE_W-1] ||
                          (byteReg[VAL_W-1:0] == liveTime[f*VAL_W +: VAL_W]);
    end

    // An alarm with nothing enabled must not match
    assign matchHit[a] = (|fieldOn) && (&fieldOk);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        repeatReg <= 1'b0;
        irqEnReg  <= 1'b0;
      end else if (strobes.ctrlWr[a]) begin
        repeatReg <= strobes.data[REPEAT_BIT];
        irqEnReg  <= strobes.data[IRQEN_BIT];
      end
    end
    assign repeatMode[a] = repeatReg;
    assign irqEnable[a]  = irqEnReg;

    // Repeat-mode pulse timer, restarts on every hit
    always_ff @(posedge clk) begin
      if (!rst_n)                   pulseCnt <= '0;
      else if (strobes.pulseLoad[a]) pulseCnt <= CNT_W'(PULSE_CYCLES);
      else if (pulseCnt != '0)      pulseCnt <= pulseCnt - 1'b1;
    end
    assign pulseBusy[a] = (pulseCnt != '0);
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  secTick,
  input  logic [LIVE_W-1:0]     liveTime,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  output logic [NUM_ALARMS-1:0] alarmFlag,
  output logic                  irqN
);
  strobe_t               strobes;
  logic [NUM_ALARMS-1:0] matchHit;
  logic [NUM_ALARMS-1:0] repeatMode;
  logic [NUM_ALARMS-1:0] irqEnable;
  logic [NUM_ALARMS-1:0] pulseBusy;

  alarm_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .secTick(secTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrEn(clrEn), .clrMask(clrMask),
    .matchHit(matchHit), .repeatMode(repeatMode),
    .irqEnable(irqEnable), .pulseBusy(pulseBusy),
    .strobes(strobes), .alarmFlag(alarmFlag), .irqN(irqN)
  );

  alarm_datapath #(.PULSE_CYCLES(PULSE_CYCLES)) uDatapath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .liveTime(liveTime),
    .matchHit(matchHit), .repeatMode(repeatMode),
    .irqEnable(irqEnable), .pulseBusy(pulseBusy)
  );
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker
  import alarm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  secTick,
  input logic                  clrEn,
  input logic [NUM_ALARMS-1:0] clrMask,
  input logic [NUM_ALARMS-1:0] alarmFlag,
  input logic                  irqN,
  input logic [NUM_ALARMS-1:0] matchHit,
  input logic [NUM_ALARMS-1:0] pulseBusy
);
  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !secTick |=> ((alarmFlag & ~$past(alarmFlag)) == '0)); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clrEn && !secTick) |=> ((alarmFlag & $past(clrMask)) == '0)); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!secTick && !clrEn) |=> $stable(alarmFlag)); // R5

  AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    secTick |=> ((alarmFlag & $past(matchHit)) == $past(matchHit))); // R8

  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmFlag == '0 && pulseBusy == '0) |-> irqN); // R7
endmodule

bind alarm_match_unit alarm_match_checker uChk (
  .clk(clk), .rst_n(rst_n), .secTick(secTick), .clrEn(clrEn), .clrMask(clrMask),
  .alarmFlag(alarmFlag), .irqN(irqN), .matchHit(matchHit), .pulseBusy(pulseBusy)
);

// File: tb/tb_alarm_match_unit.sv
`timescale 1ns/1ps
module tb_alarm_match_unit;
  localparam int PULSE = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        secTick;
  logic [41:0] liveTime;
  logic        wrEn;
  logic [3:0]  wrAddr;
  logic [7:0]  wrData;
  logic        clrEn;
  logic [1:0]  clrMask;
  logic [1:0]  alarmFlag;
  logic        irqN;

  int nChecks = 0;
  int nFails  = 0;
  bit autoOn  = 1'b0;

  alarm_match_unit #(.PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .liveTime(liveTime),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrEn(clrEn), .clrMask(clrMask), .alarmFlag(alarmFlag), .irqN(irqN)
  );

  always #4 clk = ~clk;

  // Requirement model
  logic [7:0] mReg [2][8];
  bit         mFlag [2];
  int         mCnt [2];

  function automatic bit expMatch(int a);
    bit any = 0;
    bit ok  = 1;
    for (int f = 0; f < 6; f++) begin
      if (mReg[a][f][7]) begin
        any = 1;
        if (mReg[a][f][6:0] != liveTime[f*7 +: 7]) ok = 0;
      end
    end
    return any && ok;
  endfunction

  function automatic bit expIrqN();
    bit pend = 0;
    for (int a = 0; a < 2; a++)
      if (mReg[a][6][7] && (mReg[a][6][0] ? (mCnt[a] > 0) : mFlag[a])) pend = 1;
    return !pend;
  endfunction

  function automatic logic [41:0] packLive(int s, int m, int h, int d, int mo, int dw);
    return {dw[6:0], mo[6:0], d[6:0], h[6:0], m[6:0], s[6:0]};
  endfunction

  always @(posedge clk) begin
    bit hit [2];
    if (!rst_n) begin
      for (int a = 0; a < 2; a++) begin
        mFlag[a] = 0; mCnt[a] = 0;
        for (int s = 0; s < 8; s++) mReg[a][s] = 8'h00;
      end
    end else begin
      for (int a = 0; a < 2; a++) hit[a] = secTick && expMatch(a);
      for (int a = 0; a < 2; a++) begin
        mFlag[a] = (mFlag[a] && !(clrEn && clrMask[a])) || hit[a];
        if (hit[a] && mReg[a][6][0]) mCnt[a] = PULSE;
        else if (mCnt[a] > 0)        mCnt[a] = mCnt[a] - 1;
      end
      if (wrEn) mReg[wrAddr[3]][wrAddr[2:0]] = wrData; // slot 7 stored but never used
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && autoOn) begin
      check(alarmFlag == {mFlag[1], mFlag[0]}, "R5 R10 flags", alarmFlag, {mFlag[1], mFlag[0]});
      check(irqN == expIrqN(), "R6 R7 irqN", irqN, expIrqN());
    end
  end

  task automatic wr(int addr, int data);
    wrAddr = addr[3:0]; wrData = data[7:0]; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(logic [41:0] live, bit clr, logic [1:0] mask);
    liveTime = live; secTick = 1'b1; clrEn = clr; clrMask = mask;
    @(negedge clk);
    secTick = 1'b0; clrEn = 1'b0;
  endtask

  task automatic clear(logic [1:0] mask);
    clrEn = 1'b1; clrMask = mask;
    @(negedge clk);
    clrEn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; secTick = 1'b0; liveTime = '0; wrEn = 1'b0; wrAddr = '0;
    wrData = '0; clrEn = 1'b0; clrMask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(alarmFlag == 2'b00, "R1 flags after reset", alarmFlag, 0);
    check(irqN == 1'b1, "R1 irqN after reset", irqN, 1);
    autoOn = 1'b1;

    // R3: no enabled field, interrupt enabled
    wr(6, 8'h80);
    tick('0, 0, 2'b00);
    check(alarmFlag[0] == 1'b0, "R3 no enabled field", alarmFlag[0], 0);

    // R2: seconds and minutes enabled
    wr(0, 8'h95); wr(1, 8'hB0);
    tick(packLive(8'h15, 8'h31, 0, 0, 0, 0), 0, 2'b00);
    check(alarmFlag[0] == 1'b0, "R2 minute mismatch", alarmFlag[0], 0);
    tick(packLive(8'h15, 8'h30, 8'h7F, 3, 9, 2), 0, 2'b00);
    check(alarmFlag[0] == 1'b1, "R2 enabled fields match", alarmFlag[0], 1);
    check(irqN == 1'b0, "R5 single-event irq", irqN, 0);

    // R5 clear, R4 no tick
    clear(2'b01);
    check(alarmFlag[0] == 1'b0 && irqN == 1'b1, "R5 clear", {alarmFlag[0], irqN}, 1);
    liveTime = packLive(8'h15, 8'h30, 0, 0, 0, 0);
    @(negedge clk);
    check(alarmFlag[0] == 1'b0, "R4 no tick no match", alarmFlag[0], 0);

    // R8: hit and clear together
    tick(packLive(8'h15, 8'h30, 0, 0, 0, 0), 1, 2'b01);
    check(alarmFlag[0] == 1'b1 && irqN == 1'b0, "R8 set wins", {alarmFlag[0], irqN}, 2);
    clear(2'b01);

    // R7 masked interrupt, R10 independence
    wr(8, 8'h95); wr(14, 8'h00);
    tick(packLive(8'h15, 8'h00, 0, 0, 0, 0), 0, 2'b00);
    check(alarmFlag == 2'b10, "R10 only alarm1 set", alarmFlag, 2);
    check(irqN == 1'b1, "R7 masked alarm no irq", irqN, 1);
    clear(2'b10);

    // R6 repeat pulse length
    wr(14, 8'h81);
    tick(packLive(8'h15, 8'h00, 0, 0, 0, 0), 0, 2'b00);
    check(alarmFlag[1] == 1'b1, "R6 flag set in repeat", alarmFlag[1], 1);
    for (int i = 0; i < PULSE; i++) begin
      check(irqN == 1'b0, "R6 pulse low", irqN, 0);
      @(negedge clk);
    end
    check(irqN == 1'b1, "R6 pulse ends", irqN, 1);
    clear(2'b11);

    // R9 slot 7 has no effect
    for (int s = 0; s < 6; s++) wr(s, 8'h00);
    wr(7, 8'hFF);
    tick(packLive(8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F), 0, 2'b00);
    check(alarmFlag[0] == 1'b0, "R9 slot 7 ignored", alarmFlag[0], 0);

    // Constrained random phase
    for (int it = 0; it < 3000; it++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 20) begin
        int addr = int'($urandom_range(0, 15));
        int data;
        if (addr[2:0] == 3'd6) data = int'($urandom_range(0, 255));
        else data = ($urandom_range(0, 1) ? 8'h80 : 8'h00) | int'($urandom_range(0, 3));
        wr(addr, data);
      end else if (r < 65) begin
        tick(packLive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                      $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
             ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)));
      end else if (r < 75) begin
        clear(2'($urandom_range(0, 3)));
      end else begin
        @(negedge clk);
      end
    end

    autoOn = 1'b0;
    summary();
    $finish;
  end
endmodule